// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address and a read/write/execute permission mask, or into a fault code. A request carries the address, the access being attempted as a three-bit mask, and a privilege index, where index 0 is kernel. The request is taken on a valid/ready handshake, and the page-table base is sampled in that same cycle. The walker first checks that the address is a proper sign extension of the implemented virtual width. A kernel-only superpage window is translated directly, with no memory traffic. Any other address is resolved by fetching up to three 64-bit table entries over a read port that allows one outstanding read.

Each level picks a 10-bit index from the address. Intermediate entries must be valid and readable by the kernel. The leaf entry gives per-privilege enable bits, which the walker selects by shifting with the privilege index. It also holds fault-on-access bits that take permissions away again. A denied access gets a prioritized fault code. An access mask of zero acts as a probe: it returns the translation without any permission fault. The result appears as a one-cycle pulse.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: If bits 63:43 of the address are not all equal to bit 63 (implemented width 43), the result is fault code 1 (access violation) and no memory read is made.
- R3: An address with bit 63 set and bits 42:41 equal to 2'b10, requested at privilege 0, gives code 0 and protection 3'b111 (bit0 read, bit1 write, bit2 execute). The physical address is virtual bits 39:0, with virtual bit 40 placed at physical bit 43. No memory read is made.
- R4: The same superpage window requested at any privilege other than 0 gives code 1, with no memory read.
- R5: The walk reads three entries in turn at base + index*8. The indexes are address bits 42:33, 32:23 and 22:13. The first base is `ptbr`, and each next base is entry bits 63:32 shifted left by 13.
- R6: An entry with bit 0 (valid) clear at any level gives code 2 (not valid), and no further entry is read.
- R7: A valid first- or second-level entry with bit 8 (kernel read enable) clear gives code 1.
- R8: In the leaf, read and execute are enabled by bit 8+priv, and write by bit 12+priv. If the access mask is non-zero and shares no bit with the enabled set, the result is code 1.
- R9: Leaf bits 1, 2 and 3 remove read, write and execute respectively. If the requested access is then denied, the code is 5 when execute is requested, otherwise 4 when write is requested, otherwise 3.
- R10: On success the code is 0, the physical address is (leaf bits 63:32 << 13) | address bits 12:0, and the protection is the remaining mask. On any fault the address and protection read 0.
- R11: A request with access mask 0 never gets codes 1, 3, 4 or 5 from the leaf check, and returns the translation and remaining protection.
- R12: At most one memory read is outstanding. `req_ready` is low while a request is in progress, and `rsp_valid` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken |
| req_vaddr | input | 64 | Virtual address |
| req_access | input | 3 | Access mask: bit0 read, bit1 write, bit2 execute |
| req_priv | input | 2 | Privilege index, 0 = kernel |
| ptbr | input | 64 | Physical base of the first-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Result pulse |
| rsp_code | output | 3 | 0 ok, 1 access violation, 2 not valid, 3/4/5 fault on read/write/execute |
| rsp_paddr | output | 64 | Physical address on success |
| rsp_prot | output | 3 | Granted permission mask |

## Verification
Three kinds of address are applied: malformed sign extensions of both polarities, superpage addresses at kernel and non-kernel privilege, and table addresses with distinct indexes per level. The recorded read addresses separate the index fields and base chaining from one another. Leaf patterns pair each privilege index with enable bits at neighbouring positions, which exposes a wrong shift amount. Fault-on bits are combined with multi-bit access masks to fix the fault priority, and a probe with an empty mask shows that the permission stage is bypassed. One run with a memory port that accepts only every other cycle checks that the handshake holds its request.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int PTE_W = 64;

  // entry bit positions; the walker decodes these
  localparam int PTE_VALID = 0;
  localparam int PTE_FO_LO = 1;   // fault-on read/write/exec at 1..3
  localparam int PTE_KREN  = 8;
  localparam int PTE_KWEN  = 12;

  typedef enum logic [2:0] {
    PF_NONE = 3'd0,
    PF_ACV  = 3'd1,
    PF_TNV  = 3'd2,
    PF_FOR  = 3'd3,
    PF_FOW  = 3'd4,
    PF_FOE  = 3'd5
  } pf_code_e;

  // address of the entry read at level lvl (0 = top)
  function automatic logic [63:0] entry_addr(logic [63:0] base, logic [63:0] va,
                                             int lvl, int levels, int page_bits,
                                             int idx_bits);
    int shift;
    logic [63:0] idx;
    shift = page_bits + idx_bits * (levels - 1 - lvl);
    idx = (va >> shift) & ((64'd1 << idx_bits) - 64'd1);
    return base + (idx << 3);
  endfunction

  function automatic logic [63:0] frame_base(logic [PTE_W-1:0] pte, int page_bits);
    return {32'b0, pte[63:32]} << page_bits;
  endfunction

  // bit0 read, bit1 write, bit2 execute
  function automatic logic [2:0] leaf_enables(logic [PTE_W-1:0] pte, int priv);
    logic r, w;
    r = pte[PTE_KREN + priv];
    w = pte[PTE_KWEN + priv];
    return {r, w, r};
  endfunction

  function automatic logic [2:0] strip_fault_on(logic [2:0] prot, logic [PTE_W-1:0] pte);
    return prot & ~pte[PTE_FO_LO +: 3];
  endfunction

  function automatic pf_code_e fault_on_code(logic [2:0] need);
    if (need[2]) return PF_FOE;
    if (need[1]) return PF_FOW;
    return PF_FOR;
  endfunction

endpackage

// File: rtl/ptw_addr_check.sv
module ptw_addr_check #(
  parameter int VA_BITS   = 43,
  parameter int PRIV_BITS = 2
) (
  input  logic [63:0]          va,
  input  logic [PRIV_BITS-1:0] priv,
  output logic                 sign_bad,
  output logic                 sp_hit,
  output logic                 sp_allow,
  output logic [63:0]          sp_pa
);
  localparam int HI_W    = 64 - VA_BITS;
  localparam int SEL_LO  = VA_BITS - 2;   // two-bit window selector
  localparam int HI_BIT  = VA_BITS - 3;   // copied up to physical bit 43
  localparam int LOW_W   = VA_BITS - 3;

  assign sign_bad = (va[63:VA_BITS] != {HI_W{va[63]}});
  assign sp_hit   = va[63] && (va[SEL_LO +: 2] == 2'b10);
  assign sp_allow = (priv == '0);

  always_comb begin
    sp_pa = '0;
    sp_pa[LOW_W-1:0] = va[LOW_W-1:0];
    sp_pa[43] = va[HI_BIT];
  end
endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
  import ptw_pkg::*;
#(
  parameter int PAGE_BITS = 13,
  parameter int PRIV_BITS = 2
) (
  input  logic [PTE_W-1:0]     pte,
  input  logic [63:0]          va,
  input  logic [PRIV_BITS-1:0] priv,
  input  logic [2:0]           need,
  output pf_code_e             code,
  output logic [2:0]           prot,
  output logic [63:0]          pa
);
  logic [2:0] en_mask, kept_mask;
  logic [63:0] off_mask;

  assign en_mask   = leaf_enables(pte, int'(priv));
  assign kept_mask = strip_fault_on(en_mask, pte);
  assign off_mask  = (64'd1 << PAGE_BITS) - 64'd1;

  always_comb begin
    code = PF_NONE;
    prot = kept_mask;
    pa   = frame_base(pte, PAGE_BITS) | (va & off_mask);
    if (!pte[PTE_VALID]) begin
      code = PF_TNV;
    end else if (need != 3'b000 && (en_mask & need) == 3'b000) begin
      code = PF_ACV;
    end else if (need != 3'b000 && (kept_mask & need) == 3'b000) begin
      code = fault_on_code(need);
    end
    if (code != PF_NONE) begin
      prot = '0;
      pa   = '0;
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_BITS   = 43,
  parameter int PAGE_BITS = 13,
  parameter int IDX_BITS  = 10,
  parameter int LEVELS    = 3,
  parameter int PRIV_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [63:0]          req_vaddr,
  input  logic [2:0]           req_access,
  input  logic [PRIV_BITS-1:0] req_priv,
  input  logic [63:0]          ptbr,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [63:0]          mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [63:0]          mem_rsp_data,
  output logic                 rsp_valid,
  output logic [2:0]           rsp_code,
  output logic [63:0]          rsp_paddr,
  output logic [2:0]           rsp_prot
);
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  typedef enum logic [2:0] {S_IDLE, S_DECIDE, S_ISSUE, S_WAIT, S_DONE} st_e;

  st_e                  st;
  logic [63:0]          va_q, base_q;
  logic [2:0]           acc_q;
  logic [PRIV_BITS-1:0] priv_q;
  logic [LVL_W-1:0]     lvl_q;
  pf_code_e             res_code;
  logic [63:0]          res_pa;
  logic [2:0]           res_prot;

  // named events for the checks
  logic       sign_bad, sp_hit, sp_allow;
  logic [63:0] sp_pa;
  pf_code_e   leaf_code;
  logic [2:0] leaf_prot;
  logic [63:0] leaf_pa;
  logic       rsp_take, at_leaf, mid_bad_valid, mid_bad_read, sp_grant;

  ptw_addr_check #(.VA_BITS(VA_BITS), .PRIV_BITS(PRIV_BITS)) u_chk (
    .va(va_q), .priv(priv_q), .sign_bad(sign_bad), .sp_hit(sp_hit),
    .sp_allow(sp_allow), .sp_pa(sp_pa)
  );

  ptw_leaf_eval #(.PAGE_BITS(PAGE_BITS), .PRIV_BITS(PRIV_BITS)) u_leaf (
    .pte(mem_rsp_data), .va(va_q), .priv(priv_q), .need(acc_q),
    .code(leaf_code), .prot(leaf_prot), .pa(leaf_pa)
  );

  assign rsp_take      = (st == S_WAIT) && mem_rsp_valid;
  assign at_leaf       = (lvl_q == LAST_LVL);
  assign mid_bad_valid = !mem_rsp_data[PTE_VALID];
  assign mid_bad_read  = !mem_rsp_data[PTE_KREN];
  assign sp_grant      = (st == S_DECIDE) && !sign_bad && sp_hit && sp_allow;

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_ISSUE);
  assign mem_req_addr  = entry_addr(base_q, va_q, int'(lvl_q), LEVELS, PAGE_BITS, IDX_BITS);
  assign rsp_valid     = (st == S_DONE);
  assign rsp_code      = res_code;
  assign rsp_paddr     = res_pa;
  assign rsp_prot      = res_prot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      va_q     <= '0;
      base_q   <= '0;
      acc_q    <= '0;
      priv_q   <= '0;
      lvl_q    <= '0;
      res_code <= PF_NONE;
      res_pa   <= '0;
      res_prot <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          acc_q  <= req_access;
          priv_q <= req_priv;
          base_q <= ptbr;
          lvl_q  <= '0;
          st     <= S_DECIDE;
        end
        S_DECIDE: begin
          res_pa   <= '0;
          res_prot <= '0;
          if (sign_bad || (sp_hit && !sp_allow)) begin
            res_code <= PF_ACV;
            st       <= S_DONE;
          end else if (sp_hit) begin
            res_code <= PF_NONE;
            res_pa   <= sp_pa;
            res_prot <= 3'b111;
            st       <= S_DONE;
          end else begin
            st <= S_ISSUE;
          end
        end
        S_ISSUE: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (at_leaf) begin
            res_code <= leaf_code;
            res_pa   <= leaf_pa;
            res_prot <= leaf_prot;
            st       <= S_DONE;
          end else if (mid_bad_valid) begin
            res_code <= PF_TNV;
            st       <= S_DONE;
          end else if (mid_bad_read) begin
            res_code <= PF_ACV;
            st       <= S_DONE;
          end else begin
            base_q <= frame_base(mem_rsp_data, PAGE_BITS);
            lvl_q  <= lvl_q + 1'b1;
            st     <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // outstanding-read tracker seen only by the checks
  logic rd_open;
  always_ff @(posedge clk) begin
    if (!rst_n) rd_open <= 1'b0;
    else if (mem_req_valid && mem_req_ready) rd_open <= 1'b1;
    else if (mem_rsp_valid) rd_open <= 1'b0;
  end

  // R12
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rd_open);
  // R12
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R12
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  // R2
  sign_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DECIDE && sign_bad) |=> (rsp_valid && rsp_code == PF_ACV && !mem_req_valid));
  // R3
  superpage_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_grant |=> (rsp_valid && rsp_prot == 3'b111 && rsp_code == PF_NONE));
  // R6
  walk_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && mid_bad_valid) |=> (rsp_valid && rsp_code == PF_TNV));
  // R9
  fault_on_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code >= PF_FOR) |-> (acc_q != 3'b000 && rsp_prot == 3'b000));
  // R10
  grant_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == PF_NONE && acc_q != 3'b000) |-> ((rsp_prot & acc_q) != 3'b000));
endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [2:0]  req_access = '0;
  logic [1:0]  req_priv = '0;
  logic [63:0] ptbr = 64'h0000_0000_0020_0000;
  logic        mem_req_valid, mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_code;
  logic [63:0] rsp_paddr;
  logic [2:0]  rsp_prot;

  int tests = 0, fails = 0;
  bit finished = 0;

  localparam logic [31:0] FV = 32'h1, FOR = 32'h2, FOW = 32'h4, FOE = 32'h8;
  localparam logic [31:0] KRE = 32'h100, KWE = 32'h1000;
  localparam logic [31:0] L2PFN = 32'h300, L3PFN = 32'h400;

  always #4 clk = ~clk;

  ptw_walker u0 (.*);

  // memory model: one-cycle read latency, optional every-other-cycle accept
  logic [63:0] mem [logic [63:0]];
  logic [63:0] rd_log [0:1023];
  int          nreads = 0;
  bit          stall = 0;
  logic        tog = 1'b0;

  always @(posedge clk) tog <= ~tog;
  assign mem_req_ready = stall ? tog : 1'b1;

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
      rd_log[nreads[9:0]] <= mem_req_addr;
      nreads <= nreads + 1;
    end else begin
      mem_rsp_valid <= 1'b0;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_va(int i1, int i2, int i3, int off);
    return {21'b0, 10'(i1), 10'(i2), 10'(i3), 13'(off)};
  endfunction

  task automatic set_walk(int i1, int i2, int i3, logic [63:0] p1, logic [63:0] p2,
                          logic [63:0] p3);
    mem.delete();
    mem[ptbr + 64'(i1) * 8] = p1;
    mem[(64'(L2PFN) << 13) + 64'(i2) * 8] = p2;
    mem[(64'(L3PFN) << 13) + 64'(i3) * 8] = p3;
  endtask

  task automatic run(logic [63:0] va, logic [2:0] acc, logic [1:0] priv,
                     output logic [2:0] code, output logic [63:0] pa,
                     output logic [2:0] prot, output int nrd, output int first);
    int n = 0;
    @(negedge clk);
    first = nreads;
    req_vaddr = va; req_access = acc; req_priv = priv; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 busy req_ready", {63'b0, req_ready}, 64'd0);
    while (!rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    code = rsp_code; pa = rsp_paddr; prot = rsp_prot;
    nrd = nreads - first;
    @(negedge clk);
    check("R12 pulse ends", {63'b0, rsp_valid}, 64'd0);
  endtask

  task automatic expect_res(string tag, logic [63:0] va, logic [2:0] acc, logic [1:0] priv,
                            int ecode, logic [63:0] epa, logic [2:0] eprot, int ereads);
    logic [2:0] c, p; logic [63:0] a; int nr, f;
    run(va, acc, priv, c, a, p, nr, f);
    check({tag, " code"}, 64'(c), 64'(ecode));
    check({tag, " paddr"}, a, epa);
    check({tag, " prot"}, 64'(p), 64'(eprot));
    check({tag, " reads"}, 64'(nr), 64'(ereads));
  endtask

  function automatic logic [63:0] leaf_pa(logic [31:0] pfn, int off);
    return (64'(pfn) << 13) | 64'(off);
  endfunction

  task automatic t_reset;
    check("R1 req_ready", {63'b0, req_ready}, 64'd1);
    check("R1 rsp_valid", {63'b0, rsp_valid}, 64'd0);
    check("R1 mem_req_valid", {63'b0, mem_req_valid}, 64'd0);
  endtask

  task automatic t_walk_ok;
    logic [2:0] c, p; logic [63:0] a; int nr, f;
    set_walk(5, 7, 9, {L2PFN, FV | KRE}, {L3PFN, FV | KRE}, {32'h0ABCD, FV | KRE});
    run(mk_va(5, 7, 9, 13'h123), 3'b001, 2'd0, c, a, p, nr, f);
    check("R10 walk code", 64'(c), 64'd0);
    check("R10 walk paddr", a, leaf_pa(32'h0ABCD, 13'h123));
    check("R10 walk prot", 64'(p), 64'd5);
    check("R5 read count", 64'(nr), 64'd3);
    check("R5 L1 addr", rd_log[f[9:0]], ptbr + 64'd40);
    check("R5 L2 addr", rd_log[10'(f + 1)], (64'(L2PFN) << 13) + 64'd56);
    check("R5 L3 addr", rd_log[10'(f + 2)], (64'(L3PFN) << 13) + 64'd72);
  endtask

  task automatic t_sign;
    expect_res("R2 pos bad", 64'h0000_0800_0000_0000, 3'b001, 2'd0, 1, 0, 0, 0);
    expect_res("R2 neg bad", 64'hFFFF_0000_0000_0000, 3'b001, 2'd0, 1, 0, 0, 0);
  endtask

  task automatic t_super;
    logic [63:0] va;
    va = {21'h1FFFFF, 2'b10, 1'b1, 40'h12_3456_789A};
    expect_res("R3 superpage", va, 3'b010, 2'd0, 0, 64'h0000_0812_3456_789A, 3'b111, 0);
    expect_res("R4 superpage user", va, 3'b001, 2'd2, 1, 0, 0, 0);
  endtask

  task automatic t_levels;
    set_walk(1, 2, 3, 64'h0, {L3PFN, FV | KRE}, {32'h55, FV | KRE});
    expect_res("R6 L1 invalid", mk_va(1, 2, 3, 0), 3'b001, 2'd0, 2, 0, 0, 1);
    set_walk(1, 2, 3, {L2PFN, FV}, {L3PFN, FV | KRE}, {32'h55, FV | KRE});
    expect_res("R7 L1 no kre", mk_va(1, 2, 3, 0), 3'b001, 2'd0, 1, 0, 0, 1);
    set_walk(1, 2, 3, {L2PFN, FV | KRE}, {L3PFN, FV}, {32'h55, FV | KRE});
    expect_res("R7 L2 no kre", mk_va(1, 2, 3, 0), 3'b001, 2'd0, 1, 0, 0, 2);
    set_walk(1, 2, 3, {L2PFN, FV | KRE}, {L3PFN, FV | KRE}, {32'h55, KRE});
    expect_res("R6 L3 invalid", mk_va(1, 2, 3, 0), 3'b001, 2'd0, 2, 0, 0, 3);
  endtask

  task automatic t_priv;
    set_walk(8, 9, 10, {L2PFN, FV | KRE}, {L3PFN, FV | KRE}, {32'h77, FV | KRE});
    expect_res("R8 user read denied", mk_va(8, 9, 10, 4), 3'b001, 2'd3, 1, 0, 0, 3);
    set_walk(8, 9, 10, {L2PFN, FV | KRE}, {L3PFN, FV | KRE}, {32'h77, FV | 32'h800 | 32'h8000});
    expect_res("R8 user write ok", mk_va(8, 9, 10, 4), 3'b010, 2'd3, 0, leaf_pa(32'h77, 4), 3'b111, 3);
    set_walk(8, 9, 10, {L2PFN, FV | KRE}, {L3PFN, FV | KRE}, {32'h77, FV | 32'h200});
    expect_res("R8 priv1 write denied", mk_va(8, 9, 10, 4), 3'b010, 2'd1, 1, 0, 0, 3);
  endtask

  task automatic t_fault_on;
    set_walk(2, 4, 6, {L2PFN, FV | KRE}, {L3PFN, FV | KRE}, {32'h99, FV | KRE | KWE | FOE});
    expect_res("R9 foe", mk_va(2, 4, 6, 0), 3'b100, 2'd0, 5, 0, 0, 3);
    set_walk(2, 4, 6, {L2PFN, FV | KRE}, {L3PFN, FV | KRE}, {32'h99, FV | KRE | KWE | FOW});
    expect_res("R9 fow", mk_va(2, 4, 6, 0), 3'b010, 2'd0, 4, 0, 0, 3);
    set_walk(2, 4, 6, {L2PFN, FV | KRE}, {L3PFN, FV | KRE}, {32'h99, FV | KRE | FOR});
    expect_res("R9 for", mk_va(2, 4, 6, 0), 3'b001, 2'd0, 3, 0, 0, 3);
    set_walk(2, 4, 6, {L2PFN, FV | KRE}, {L3PFN, FV | KRE},
             {32'h99, FV | KRE | KWE | FOR | FOW | FOE});
    expect_res("R9 prio exec", mk_va(2, 4, 6, 0), 3'b111, 2'd0, 5, 0, 0, 3);
    expect_res("R9 prio write", mk_va(2, 4, 6, 0), 3'b011, 2'd0, 4, 0, 0, 3);
    set_walk(2, 4, 6, {L2PFN, FV | KRE}, {L3PFN, FV | KRE}, {32'h99, FV | KRE | FOE});
    expect_res("R9 partial strip", mk_va(2, 4, 6, 13'h1FFF), 3'b001, 2'd0, 0,
               leaf_pa(32'h99, 13'h1FFF), 3'b001, 3);
  endtask

  task automatic t_probe;
    set_walk(3, 3, 3, {L2PFN, FV | KRE}, {L3PFN, FV | KRE}, {32'h1234, FV});
    expect_res("R11 probe no enables", mk_va(3, 3, 3, 13'h10), 3'b000, 2'd3, 0,
               leaf_pa(32'h1234, 13'h10), 3'b000, 3);
    set_walk(3, 3, 3, {L2PFN, FV | KRE}, {L3PFN, FV | KRE}, {32'h1234, FV | KRE | FOR});
    expect_res("R11 probe fault-on", mk_va(3, 3, 3, 13'h10), 3'b000, 2'd0, 0,
               leaf_pa(32'h1234, 13'h10), 3'b100, 3);
  endtask

  task automatic t_stall;
    stall = 1;
    set_walk(511, 0, 1023, {L2PFN, FV | KRE}, {L3PFN, FV | KRE}, {32'hFFFF_FFFF, FV | KRE | KWE});
    expect_res("R12 stalled walk", mk_va(511, 0, 1023, 7), 3'b010, 2'd0, 0,
               leaf_pa(32'hFFFF_FFFF, 7), 3'b111, 3);
    stall = 0;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_walk_ok();
    t_sign();
    t_super();
    t_levels();
    t_priv();
    t_fault_on();
    t_probe();
    t_stall();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule